// File: doc/BRIEF.md
# Linked Descriptor Queue Walker

This block runs one direction of an endpoint's transfer queue. Software builds a ring of 16-byte descriptors in memory and hands the block the address of the first one. The walker reads each descriptor as four 32-bit words over a one-outstanding read port, which returns data some cycles later. It keeps a running byte sum and then judges the descriptor: ownership, checksum (when enabled) and the skip flag. A descriptor that passes becomes a transfer command: buffer address, length and, for transmit, a zero-length-packet request. The command is held until the data mover reports completion.

After completion the walker writes the results back into the descriptor. A receive walker stores the byte count it was given. Both directions then rewrite the flag byte with ownership cleared. The walker optionally raises a completion interrupt and then follows the descriptor's next pointer. Buffer and next pointers are 32 bits, and each is widened by a 4-bit extension taken from the descriptor. Where that extension lives, and which field gives the length, depend on the direction chosen by a parameter. When the walker reaches a descriptor that software still owns, or one with a bad checksum, it parks. A resume pulse makes it fetch the same descriptor again.

Top module: `dqw_walker`

## Requirements
- R1: After reset no read, write, transfer command or interrupt output is active, and the walker issues no read until a start or resume pulse.
- R2: On a start pulse the walker reads the descriptor at start_addr as four words at offsets +0, +4, +8, +12, one read at a time. The layout is little-endian. Word 0 holds flag (bits 7:0), checksum (15:8) and a 16-bit field (31:16). Word 1 is the low 32 bits of the next pointer and word 2 the low 32 bits of the buffer pointer. Word 3 holds the length (15:0), byte 14 (23:16) and the extension-flag byte (31:24).
- R3: A descriptor whose flag bit 0 (hardware-own) is clear produces no transfer and no write, and the walker goes idle. A resume pulse refetches the same address.
- R4: A descriptor with bit 0 and bit 2 (bypass) both set is skipped: there is no transfer and no write, and the walker moves on to its next pointer.
- R5: The transfer command is held with stable address and length until xfer_done. Its address is {buffer extension, buffer pointer}. For transmit, the length is the word 3 length field, and xfer_zlp is extension-flag bit 5 (word 3 bit 29). For receive, the length is the capacity in word 0 bits 31:16, and xfer_zlp is 0.
- R6: With cs_en high, a descriptor whose 16 bytes do not sum to 0xFF modulo 256 gives a one-cycle err_irq pulse, no transfer and no write, and the walker parks. With cs_en low the sum is ignored.
- R7: After xfer_done, a receive walker writes xfer_count to bytes 12–13 (word at +12, strobe 0011). Both directions then write the flag byte with bit 0 cleared (word at +0, strobe 0001). done_irq pulses for one cycle only if flag bit 7 is set.
- R8: After a completion or a skip, the next fetch starts at {next extension, next pointer}. For transmit the buffer extension is word 0 bits 19:16 and the next extension is bits 23:20. For receive they are word 3 bits 19:16 and bits 23:20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin walking at start_addr (taken when idle) |
| start_addr | input | 36 | Extended address of the first descriptor |
| resume | input | 1 | Refetch the current descriptor (taken when idle) |
| cs_en | input | 1 | Enable checksum validation |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | 36 | Read byte address |
| rd_valid | input | 1 | Read data returned |
| rd_data | input | 32 | Read data word |
| wr_en | output | 1 | Write strobe |
| wr_addr | output | 36 | Write byte address |
| wr_data | output | 32 | Write data word |
| wr_strb | output | 4 | Byte enables for the write |
| xfer_req | output | 1 | Transfer command pending |
| xfer_addr | output | 36 | Extended buffer address |
| xfer_len | output | 16 | Buffer length or capacity |
| xfer_zlp | output | 1 | Zero-length packet requested |
| xfer_done | input | 1 | Data mover finished the command |
| xfer_count | input | 16 | Bytes received (receive walker) |
| done_irq | output | 1 | Completion interrupt pulse |
| err_irq | output | 1 | Checksum error pulse |

## Verification
The bench builds two copies with the default 4-bit extension: u0 with IS_RX=1 and u1 with IS_RX=0. The receive copy exercises the length write-back, the byte-14 extension and the checksum-error-then-retry path. The transmit copy reaches the zero-length-packet flag and the extension in bytes 2–3. Both rings use nonzero next-pointer extensions, so a walker that dropped the upper address bits would issue the wrong fetch address.

// File: rtl/dqw_pkg.sv
package dqw_pkg;
    localparam int WORD_W     = 32;
    localparam int DESC_WORDS = 4;
    localparam int PTR_W      = 32;
    localparam int LEN_W      = 16;
    localparam int FLAG_HWO   = 0;
    localparam int FLAG_BPS   = 2;
    localparam int FLAG_IOC   = 7;
    localparam int EF_ZLP     = 5;
    localparam logic [7:0] SUM_GOOD = 8'hFF;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_WAIT,
        ST_CHECK,
        ST_XFER,
        ST_WB_LEN,
        ST_WB_FLAG
    } walk_st_e;
endpackage

// File: rtl/dqw_bytesum.sv
module dqw_bytesum
    import dqw_pkg::*;
(
    input  logic [WORD_W-1:0] word,
    output logic [7:0]        sum
);
    localparam int NBYTES = WORD_W / 8;

    always_comb begin
        sum = '0;
        for (int b = 0; b < NBYTES; b++) begin
            sum = sum + word[8*b +: 8];
        end
    end
endmodule

// File: rtl/dqw_decode.sv
module dqw_decode
    import dqw_pkg::*;
#(
    parameter bit IS_RX = 1'b1,
    parameter int EXT_W = 4,
    localparam int ADDR_W = PTR_W + EXT_W
) (
    input  logic [DESC_WORDS-1:0][WORD_W-1:0] words,
    output logic                              hwo,
    output logic                              bypass,
    output logic                              ioc,
    output logic                              zlp,
    output logic [ADDR_W-1:0]                 buf_addr,
    output logic [ADDR_W-1:0]                 next_addr,
    output logic [LEN_W-1:0]                  len
);
    logic [7:0] ext_byte;
    logic       dec_unused;

    assign hwo    = words[0][FLAG_HWO];
    assign bypass = words[0][FLAG_BPS];
    assign ioc    = words[0][FLAG_IOC];

    generate
        if (IS_RX) begin : g_rx
            assign ext_byte = words[3][23:16];
            assign len      = words[0][31:16];
            assign zlp      = 1'b0;
        end else begin : g_tx
            assign ext_byte = words[0][23:16];
            assign len      = words[3][15:0];
            assign zlp      = words[3][24 + EF_ZLP];
        end
    endgenerate

    assign buf_addr  = {ext_byte[EXT_W-1:0], words[2]};
    assign next_addr = {ext_byte[4 +: EXT_W], words[1]};
    assign dec_unused = ^words;
endmodule

// File: rtl/dqw_walker.sv
module dqw_walker
    import dqw_pkg::*;
#(
    parameter bit IS_RX = 1'b1,
    parameter int EXT_W = 4,
    localparam int ADDR_W = PTR_W + EXT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              resume,
    input  logic              cs_en,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic [WORD_W-1:0] rd_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic [3:0]        wr_strb,
    output logic              xfer_req,
    output logic [ADDR_W-1:0] xfer_addr,
    output logic [LEN_W-1:0]  xfer_len,
    output logic              xfer_zlp,
    input  logic              xfer_done,
    input  logic [LEN_W-1:0]  xfer_count,
    output logic              done_irq,
    output logic              err_irq
);
    localparam int IDX_W   = $clog2(DESC_WORDS);
    localparam int LEN_OFF = 12;

    typedef struct packed {
        walk_st_e                         st;
        logic [IDX_W-1:0]                 idx;
        logic [ADDR_W-1:0]                cur;
        logic [DESC_WORDS-1:0][WORD_W-1:0] w;
        logic [7:0]                       sum;
        logic [LEN_W-1:0]                 cnt;
        logic                             done_irq;
        logic                             err_irq;
    } walk_regs_t;

    walk_regs_t r_d, r_q;

    logic              d_hwo, d_bypass, d_ioc, d_zlp;
    logic [ADDR_W-1:0] d_buf, d_next;
    logic [LEN_W-1:0]  d_len;
    logic [7:0]        word_sum;
    logic [7:0]        flag_clr;

    function automatic logic [ADDR_W-1:0] at_off(input logic [ADDR_W-1:0] base,
                                                 input logic [PTR_W-1:0]  off);
        return {base[ADDR_W-1:PTR_W], base[PTR_W-1:0] + off};
    endfunction

    dqw_decode #(.IS_RX(IS_RX), .EXT_W(EXT_W)) u_dec (
        .words     (r_q.w),
        .hwo       (d_hwo),
        .bypass    (d_bypass),
        .ioc       (d_ioc),
        .zlp       (d_zlp),
        .buf_addr  (d_buf),
        .next_addr (d_next),
        .len       (d_len)
    );

    dqw_bytesum u_sum (
        .word (rd_data),
        .sum  (word_sum)
    );

    always_comb begin
        r_d          = r_q;
        r_d.done_irq = 1'b0;
        r_d.err_irq  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.cur = start_addr;
                    r_d.idx = '0;
                    r_d.sum = '0;
                    r_d.st  = ST_FETCH;
                end else if (resume) begin
                    r_d.idx = '0;
                    r_d.sum = '0;
                    r_d.st  = ST_FETCH;
                end
            end
            ST_FETCH: r_d.st = ST_WAIT;
            ST_WAIT: begin
                if (rd_valid) begin
                    r_d.w[r_q.idx] = rd_data;
                    r_d.sum        = r_q.sum + word_sum;
                    if (r_q.idx == IDX_W'(DESC_WORDS - 1)) begin
                        r_d.st = ST_CHECK;
                    end else begin
                        r_d.idx = r_q.idx + 1'b1;
                        r_d.st  = ST_FETCH;
                    end
                end
            end
            ST_CHECK: begin
                if (!d_hwo) begin
                    r_d.st = ST_IDLE;
                end else if (cs_en && (r_q.sum != SUM_GOOD)) begin
                    r_d.err_irq = 1'b1;
                    r_d.st      = ST_IDLE;
                end else if (d_bypass) begin
                    r_d.cur = d_next;
                    r_d.idx = '0;
                    r_d.sum = '0;
                    r_d.st  = ST_FETCH;
                end else begin
                    r_d.st = ST_XFER;
                end
            end
            ST_XFER: begin
                if (xfer_done) begin
                    r_d.cnt = xfer_count;
                    r_d.st  = IS_RX ? ST_WB_LEN : ST_WB_FLAG;
                end
            end
            ST_WB_LEN: r_d.st = ST_WB_FLAG;
            ST_WB_FLAG: begin
                r_d.done_irq = d_ioc;
                r_d.cur      = d_next;
                r_d.idx      = '0;
                r_d.sum      = '0;
                r_d.st       = ST_FETCH;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        flag_clr           = r_q.w[0][7:0];
        flag_clr[FLAG_HWO] = 1'b0;
    end

    assign rd_req    = (r_q.st == ST_FETCH);
    assign rd_addr   = at_off(r_q.cur, {{(PTR_W - IDX_W - 2){1'b0}}, r_q.idx, 2'b00});
    assign xfer_req  = (r_q.st == ST_XFER);
    assign xfer_addr = d_buf;
    assign xfer_len  = d_len;
    assign xfer_zlp  = d_zlp;
    assign wr_en     = (r_q.st == ST_WB_LEN) || (r_q.st == ST_WB_FLAG);
    assign wr_addr   = (r_q.st == ST_WB_LEN) ? at_off(r_q.cur, PTR_W'(LEN_OFF)) : r_q.cur;
    assign wr_strb   = (r_q.st == ST_WB_LEN) ? 4'b0011 : 4'b0001;
    assign wr_data   = (r_q.st == ST_WB_LEN) ? {{(WORD_W - LEN_W){1'b0}}, r_q.cnt}
                                             : {{(WORD_W - 8){1'b0}}, flag_clr};
    assign done_irq  = r_q.done_irq;
    assign err_irq   = r_q.err_irq;

    AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req); // R2
    AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !xfer_done) |=> (xfer_req && $stable(xfer_addr) && $stable(xfer_len))); // R5
    AST_ERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq |-> (!xfer_req && !wr_en)); // R6
    AST_OWN_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_strb == 4'b0001) |-> !wr_data[FLAG_HWO]); // R7
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_irq |=> !done_irq); // R7
endmodule

// File: tb/sim_dqw_walker.sv
`timescale 1ns/1ps
module sim_port (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        rd_req,
    input  logic [35:0] rd_addr,
    output logic        rd_valid,
    output logic [31:0] rd_data,
    input  logic        wr_en,
    input  logic [35:0] wr_addr,
    input  logic [31:0] wr_data,
    input  logic [3:0]  wr_strb,
    input  logic        xfer_req,
    input  logic [15:0] xfer_len,
    output logic        xfer_done,
    output logic [15:0] xfer_count
);
    logic [31:0] mem [64];
    logic [35:0] rd_log [$];
    logic        pend, busy;
    logic [1:0]  dly, xc;
    logic [5:0]  ra;

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
    end

    task automatic put(input int i, input logic [31:0] v);
        mem[i] = v;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 0; rd_data <= '0; pend <= 0; dly <= '0; ra <= '0;
            busy <= 0; xc <= '0; xfer_done <= 0; xfer_count <= '0;
        end else begin
            rd_valid  <= 0;
            xfer_done <= 0;
            if (pend) begin
                if (dly == 0) begin
                    rd_valid <= 1; rd_data <= mem[ra]; pend <= 0;
                end else dly <= dly - 1;
            end
            if (rd_req) begin
                pend <= 1; dly <= 2'd1; ra <= rd_addr[7:2];
                rd_log.push_back(rd_addr);
            end
            if (wr_en) begin
                for (int b = 0; b < 4; b++)
                    if (wr_strb[b]) mem[wr_addr[7:2]][8*b +: 8] <= wr_data[8*b +: 8];
            end
            if (xfer_req && !xfer_done && !busy) begin
                busy <= 1; xc <= 2'd3;
            end
            if (busy) begin
                if (xc == 0) begin
                    xfer_done <= 1; xfer_count <= xfer_len >> 1; busy <= 0;
                end else xc <= xc - 1;
            end
        end
    end
endmodule

module sim_dqw_walker;
    logic clk = 0;
    logic rst_n = 0;
    always #2 clk = ~clk;

    int n_chk = 0, n_fail = 0;
    int rx_done = 0, rx_err = 0, tx_done = 0, tx_err = 0, rx_cmds = 0;

    logic        r_start = 0, r_resume = 0, r_cs = 1;
    logic [35:0] r_saddr = '0;
    logic        r_rd_req, r_rd_valid, r_wr_en, r_xreq, r_xzlp, r_xdone, r_dirq, r_eirq;
    logic [35:0] r_rd_addr, r_wr_addr, r_xaddr;
    logic [31:0] r_rd_data, r_wr_data;
    logic [3:0]  r_wr_strb;
    logic [15:0] r_xlen, r_xcnt;

    logic        t_start = 0, t_resume = 0, t_cs = 1;
    logic [35:0] t_saddr = '0;
    logic        t_rd_req, t_rd_valid, t_wr_en, t_xreq, t_xzlp, t_xdone, t_dirq, t_eirq;
    logic [35:0] t_rd_addr, t_wr_addr, t_xaddr;
    logic [31:0] t_rd_data, t_wr_data;
    logic [3:0]  t_wr_strb;
    logic [15:0] t_xlen, t_xcnt;

    dqw_walker #(.IS_RX(1'b1), .EXT_W(4)) u0 (
        .clk(clk), .rst_n(rst_n), .start(r_start), .start_addr(r_saddr), .resume(r_resume),
        .cs_en(r_cs), .rd_req(r_rd_req), .rd_addr(r_rd_addr), .rd_valid(r_rd_valid),
        .rd_data(r_rd_data), .wr_en(r_wr_en), .wr_addr(r_wr_addr), .wr_data(r_wr_data),
        .wr_strb(r_wr_strb), .xfer_req(r_xreq), .xfer_addr(r_xaddr), .xfer_len(r_xlen),
        .xfer_zlp(r_xzlp), .xfer_done(r_xdone), .xfer_count(r_xcnt),
        .done_irq(r_dirq), .err_irq(r_eirq));

    dqw_walker #(.IS_RX(1'b0), .EXT_W(4)) u1 (
        .clk(clk), .rst_n(rst_n), .start(t_start), .start_addr(t_saddr), .resume(t_resume),
        .cs_en(t_cs), .rd_req(t_rd_req), .rd_addr(t_rd_addr), .rd_valid(t_rd_valid),
        .rd_data(t_rd_data), .wr_en(t_wr_en), .wr_addr(t_wr_addr), .wr_data(t_wr_data),
        .wr_strb(t_wr_strb), .xfer_req(t_xreq), .xfer_addr(t_xaddr), .xfer_len(t_xlen),
        .xfer_zlp(t_xzlp), .xfer_done(t_xdone), .xfer_count(t_xcnt),
        .done_irq(t_dirq), .err_irq(t_eirq));

    sim_port mp_rx (
        .clk(clk), .rst_n(rst_n), .rd_req(r_rd_req), .rd_addr(r_rd_addr), .rd_valid(r_rd_valid),
        .rd_data(r_rd_data), .wr_en(r_wr_en), .wr_addr(r_wr_addr), .wr_data(r_wr_data),
        .wr_strb(r_wr_strb), .xfer_req(r_xreq), .xfer_len(r_xlen), .xfer_done(r_xdone),
        .xfer_count(r_xcnt));

    sim_port mp_tx (
        .clk(clk), .rst_n(rst_n), .rd_req(t_rd_req), .rd_addr(t_rd_addr), .rd_valid(t_rd_valid),
        .rd_data(t_rd_data), .wr_en(t_wr_en), .wr_addr(t_wr_addr), .wr_data(t_wr_data),
        .wr_strb(t_wr_strb), .xfer_req(t_xreq), .xfer_len(t_xlen), .xfer_done(t_xdone),
        .xfer_count(t_xcnt));

    logic [52:0] q_rx [$];
    logic [52:0] q_tx [$];
    logic r_prev = 0, t_prev = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] sum4(input logic [31:0] v);
        return v[7:0] + v[15:8] + v[23:16] + v[31:24];
    endfunction

    task automatic load(input bit tx, input int base, input logic [7:0] flag,
                        input logic [15:0] f16, input logic [31:0] nxt, input logic [31:0] bufp,
                        input logic [15:0] len, input logic [7:0] b14, input logic [7:0] ef,
                        input bit bad);
        logic [31:0] w0, w3;
        logic [7:0]  s, ck;
        w3 = {ef, b14, len};
        s  = flag + f16[7:0] + f16[15:8] + sum4(nxt) + sum4(bufp) + sum4(w3);
        ck = 8'hFF - s;
        if (bad) ck = ck + 8'd1;
        w0 = {f16, ck, flag};
        if (tx) begin
            mp_tx.put(base/4, w0); mp_tx.put(base/4+1, nxt);
            mp_tx.put(base/4+2, bufp); mp_tx.put(base/4+3, w3);
        end else begin
            mp_rx.put(base/4, w0); mp_rx.put(base/4+1, nxt);
            mp_rx.put(base/4+2, bufp); mp_rx.put(base/4+3, w3);
        end
    endtask

    // Scoreboard monitor: each new command is compared with the oldest expected one (R5)
    always @(negedge clk) begin
        if (rst_n) begin
            if (r_xreq && !r_prev) begin
                rx_cmds++;
                if (q_rx.size() == 0) chk("R5 rx unexpected command", {11'b0, r_xzlp, r_xlen, r_xaddr}, 64'h0);
                else chk("R5 rx command", {11'b0, r_xzlp, r_xlen, r_xaddr}, {11'b0, q_rx.pop_front()});
            end
            if (t_xreq && !t_prev) begin
                if (q_tx.size() == 0) chk("R5 tx unexpected command", {11'b0, t_xzlp, t_xlen, t_xaddr}, 64'h0);
                else chk("R5 tx command", {11'b0, t_xzlp, t_xlen, t_xaddr}, {11'b0, q_tx.pop_front()});
            end
            if (r_dirq) rx_done++;
            if (r_eirq) rx_err++;
            if (t_dirq) tx_done++;
            if (t_eirq) tx_err++;
        end
        r_prev <= r_xreq;
        t_prev <= t_xreq;
    end

    function automatic bit seen(input bit tx, input logic [35:0] a);
        if (tx) begin
            foreach (mp_tx.rd_log[i]) if (mp_tx.rd_log[i] == a) return 1;
        end else begin
            foreach (mp_rx.rd_log[i]) if (mp_rx.rd_log[i] == a) return 1;
        end
        return 0;
    endfunction

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int s;
        repeat (3) @(negedge clk);
        chk("R1 outputs in reset", {r_rd_req, r_wr_en, r_xreq, r_dirq, r_eirq, t_rd_req, t_wr_en, t_xreq}, 0);
        rst_n = 1;
        repeat (10) @(negedge clk);
        chk("R1 outputs after reset", {r_rd_req, r_wr_en, r_xreq, r_dirq, r_eirq, t_rd_req, t_wr_en, t_xreq}, 0);
        chk("R1 no reads before start", mp_rx.rd_log.size() + mp_tx.rd_log.size(), 0);

        // Receive ring: A (ioc, ext 5/3) -> B (bypass) -> C -> D (not owned)
        load(0, 'h00, 8'h81, 16'h0200, 32'h20, 32'h1000, 16'h0, 8'h53, 8'h0, 0);
        load(0, 'h20, 8'h05, 16'h0000, 32'h40, 32'h0,    16'h0, 8'h00, 8'h0, 0);
        load(0, 'h40, 8'h01, 16'h0040, 32'h60, 32'h2000, 16'h0, 8'h00, 8'h0, 0);
        load(0, 'h60, 8'h80, 16'h0010, 32'h00, 32'h3000, 16'h0, 8'h00, 8'h0, 0);
        q_rx.push_back({1'b0, 16'h0200, 36'h3_0000_1000});
        q_rx.push_back({1'b0, 16'h0040, 36'h0_0000_2000});
        r_saddr = '0; r_start = 1;
        @(negedge clk); r_start = 0;
        repeat (300) @(negedge clk);
        chk("R2 fetch order", {mp_rx.rd_log[0][15:0], mp_rx.rd_log[1][15:0], mp_rx.rd_log[2][15:0], mp_rx.rd_log[3][15:0]},
            64'h0000_0004_0008_000C);
        chk("R8 extended next fetched", seen(0, 36'h5_0000_0020), 1);
        chk("R7 rx length written", mp_rx.mem[3], 32'h0053_0100);
        chk("R7 rx ownership cleared A", mp_rx.mem[0][7:0], 8'h80);
        chk("R7 rx ownership cleared C", mp_rx.mem[16][7:0], 8'h00);
        chk("R7 rx length written C", mp_rx.mem[19], 32'h0000_0020);
        chk("R4 bypass not written", {mp_rx.mem[8][7:0], mp_rx.mem[11]}, {8'h05, 32'h0});
        chk("R7 ioc interrupt count", rx_done, 1);
        s = mp_rx.rd_log.size();
        repeat (40) @(negedge clk);
        chk("R3 idle after unowned", mp_rx.rd_log.size(), s);
        chk("R3 unowned not written", mp_rx.mem[24][7:0], 8'h80);
        chk("R5 rx queue drained", q_rx.size(), 0);

        // Software hands D over and resumes
        load(0, 'h60, 8'h81, 16'h0010, 32'h00, 32'h3000, 16'h0, 8'h00, 8'h0, 0);
        q_rx.push_back({1'b0, 16'h0010, 36'h0_0000_3000});
        r_resume = 1;
        @(negedge clk); r_resume = 0;
        repeat (300) @(negedge clk);
        chk("R3 resume refetch completes", rx_done, 2);
        chk("R7 rx length written D", mp_rx.mem[27][15:0], 16'h0008);
        chk("R5 rx queue drained after resume", q_rx.size(), 0);

        // Bad checksum at E
        load(0, 'h80, 8'h81, 16'h0020, 32'h00, 32'h4000, 16'h0, 8'h00, 8'h0, 1);
        s = rx_cmds;
        r_saddr = 36'h80; r_start = 1;
        @(negedge clk); r_start = 0;
        repeat (200) @(negedge clk);
        chk("R6 error interrupt", rx_err, 1);
        chk("R6 no command on error", rx_cmds, s);
        chk("R6 no write on error", mp_rx.mem[32][7:0], 8'h81);
        r_cs = 0;
        q_rx.push_back({1'b0, 16'h0020, 36'h0_0000_4000});
        r_resume = 1;
        @(negedge clk); r_resume = 0;
        repeat (200) @(negedge clk);
        chk("R6 sum ignored when disabled", rx_done, 3);
        chk("R6 owned cleared after retry", mp_rx.mem[32][7:0], 8'h80);
        chk("R6 no further error", rx_err, 1);

        // Transmit ring: T0 (zlp, ext 1/2, ioc) -> T1 -> back to T0 (cleared)
        load(1, 'h00, 8'h81, 16'h0012, 32'h20, 32'h5000, 16'h0100, 8'h00, 8'h20, 0);
        load(1, 'h20, 8'h01, 16'h0000, 32'h00, 32'h6000, 16'h0010, 8'h00, 8'h00, 0);
        q_tx.push_back({1'b1, 16'h0100, 36'h2_0000_5000});
        q_tx.push_back({1'b0, 16'h0010, 36'h0_0000_6000});
        t_saddr = '0; t_start = 1;
        @(negedge clk); t_start = 0;
        repeat (300) @(negedge clk);
        chk("R8 tx extended next fetched", seen(1, 36'h1_0000_0020), 1);
        chk("R7 tx length field untouched", mp_tx.mem[3], 32'h2000_0100);
        chk("R7 tx ownership cleared", {mp_tx.mem[0][7:0], mp_tx.mem[8][7:0]}, {8'h80, 8'h00});
        chk("R7 tx ioc count", {tx_done, tx_err}, {32'd1, 32'd0});
        chk("R5 tx queue drained", q_tx.size(), 0);
        finish_run();
    end
endmodule